// File: doc/BRIEF.md
# Deflection Safety and Drive Gating

This block is the digital protection and output-gating stage of a monitor deflection controller. It keeps a latched X-ray fault and merges it with two supply-low flags, the flyback state and three enable bits from the control registers. The result gates the horizontal drive, the vertical ramp enable and the B+ step-up switch. The comparators and analog references sit outside the block and reach it only as synchronous digital inputs.

The block measures each horizontal line from one flyback rising edge to the next, and it measures the width of each flyback pulse. From these it derives three things. The first is the drive off-interval, which sets the duty cycle from a 5-bit code. The second is the mid-flyback instant at which the B+ switch turns on. The third is a maximum on-time for that switch. After the switch turns off, it stays off for a minimum number of clock cycles, set by a parameter (20 cycles, which is 400 ns at 50 MHz).

Top module: `defl_safety_gate`

## Requirements
- R1: While `xray_i` is 1 at a clock edge, `fault_o` is 1 from the next cycle. A set request wins over a clear request in the same cycle.
- R2: Once set, `fault_o` stays 1 until a cycle in which `xray_i` is 0 and at least one of `vcc_low_i`, `vdd_low_i` or `xray_clr_i` is 1. It is 0 from the following cycle. `xray_i` going low has no effect on it.
- R3: `hdrv_o` is 0 in any cycle where any of these holds: `vcc_low_i` is 1, `vdd_low_i` is 1, `fault_o` is 1, `flyback_i` is 1, or `hdrv_en_i` is 0.
- R4: Let P be the line length in cycles, measured between the last two flyback rising edges. Let c be a duty code. After each flyback rising edge, `hdrv_o` stays off for the first floor(P*(39+c+floor(c/4))/128) cycles of the line, counting the rise cycle as 1. This gives about 30% (c=0) to 60% (c=31). The code in effect is the one sampled at the previous rising edge. Its reset value is 31, so the first measured line runs at the 60% off-fraction.
- R5: `hdrv_o` stays 0 until two flyback rising edges have been seen after reset.
- R6: `vramp_o` equals `vramp_en_i` whenever both supply-low flags are 0, and is 0 otherwise, in the same cycle.
- R7: A B+ pulse can begin only in the cycle when the count of cycles since the flyback rise (rise cycle = 0) equals floor(W/2), where W is the previous flyback width. `flyback_i` must still be 1 in that cycle. `bplus_o` rises in the next cycle. At most one pulse starts per line.
- R8: When `isense_trip_i` is 1 while `bplus_o` is 1, `bplus_o` is 0 from the next cycle.
- R9: Without a trip, a B+ pulse lasts floor(P*6/8) cycles.
- R10: Between the end of a B+ pulse and the start of the next, `bplus_o` is low for at least MIN_OFF_CYC cycles. A mid-flyback instant that falls inside this interval starts no pulse.
- R11: `bplus_o` is 0 while either supply is low, while `fault_o` is 1, or while `bplus_en_i` is 0. If any of these holds at a clock edge during a pulse, the pulse ends.
- R12: After reset, `hdrv_o`, `bplus_o` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xray_i | input | 1 | X-ray comparator trip, high = overvoltage |
| vcc_low_i | input | 1 | Main supply below threshold |
| vdd_low_i | input | 1 | Logic supply below threshold |
| xray_clr_i | input | 1 | Single-cycle fault clear command from the register file |
| flyback_i | input | 1 | Horizontal flyback active |
| isense_trip_i | input | 1 | B+ switch current above limit |
| hdrv_en_i | input | 1 | Horizontal drive enable bit |
| vramp_en_i | input | 1 | Vertical ramp enable bit |
| bplus_en_i | input | 1 | B+ converter enable bit |
| duty_code_i | input | 5 | Horizontal drive duty code |
| hdrv_o | output | 1 | Gated horizontal drive, high = transistor conducting |
| vramp_o | output | 1 | Vertical ramp enable after gating |
| bplus_o | output | 1 | Gated B+ switch drive |
| fault_o | output | 1 | Latched X-ray fault |

## Verification
The hardest state to reach is a B+ pulse whose forced off-interval still runs when the next line's mid-flyback arrives. With normal line lengths, the 75% on-time cap always leaves enough of the line for the off-interval to expire. The stimulus therefore shortens the line to 30 cycles with no current trip. Each pulse then runs to its cap, and the off-interval swallows the next start, so pulses appear only on alternate lines. A second awkward case is the duty code change, which takes effect one line late. The bench alters the code on consecutive lines, so an implementation that applies the code at once shows a different off-count.

// File: rtl/defl_pkg.sv
// Package: shared constants and the duty-code mapping for the deflection
// safety block. Assumes a 5-bit duty code and a 7-bit fractional scale.
package defl_pkg;

    localparam int DUTY_CODE_W    = 5;
    localparam int DUTY_FRAC_BITS = 7;
    localparam logic [DUTY_CODE_W-1:0] DUTY_RESET_CODE = 5'd31;

    // Off-interval numerator in 128ths of a line: about 30% to 60%.
    function automatic logic [DUTY_FRAC_BITS-1:0] duty_num(input logic [DUTY_CODE_W-1:0] code);
        return 7'd39 + {2'b00, code} + {4'b0000, code[4:2]};
    endfunction

endpackage

// File: rtl/defl_line_timer.sv
// Line timer: measures the horizontal line from flyback rise to flyback rise
// and the flyback width. Assumes flyback_i is synchronous to clk.
// pos_o is 1 in the cycle after a rise. The position counter saturates.
module defl_line_timer #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flyback_i,
    output logic              line_rise_o,
    output logic [LINE_W-1:0] pos_o,
    output logic [LINE_W-1:0] width_o,
    output logic              period_ok_o,
    output logic              width_ok_o
);
    localparam logic [LINE_W-1:0] POS_MAX = '1;

    logic fb_q, seen_q, fall;

    assign line_rise_o = flyback_i & ~fb_q;
    assign fall        = ~flyback_i & fb_q;

    // Edge history of the flyback input.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= 1'b0;
        else        fb_q <= flyback_i;
    end

    // Position within the line, restarted at each flyback rise.
    always_ff @(posedge clk) begin
        if (!rst_n)               pos_o <= '0;
        else if (line_rise_o)     pos_o <= LINE_W'(1);
        else if (pos_o != POS_MAX) pos_o <= pos_o + LINE_W'(1);
    end

    // Validity: one rise starts measurement, the second makes the period valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            period_ok_o <= 1'b0;
        end else if (line_rise_o) begin
            seen_q      <= 1'b1;
            period_ok_o <= seen_q;
        end
    end

    // Flyback width captured at the falling edge of a measured line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_o    <= '0;
            width_ok_o <= 1'b0;
        end else if (fall && seen_q) begin
            width_o    <= pos_o;
            width_ok_o <= 1'b1;
        end
    end

endmodule

// File: rtl/defl_hdrv_duty.sv
// Horizontal drive duty: at each line boundary it computes the off-interval
// from the just-measured line length and the code sampled one boundary earlier.
// Assumes pos_i holds the line length in the rise cycle.
module defl_hdrv_duty
    import defl_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_rise_i,
    input  logic [LINE_W-1:0]      pos_i,
    input  logic [DUTY_CODE_W-1:0] duty_code_i,
    output logic                   drive_phase_o
);
    localparam int PW = LINE_W + DUTY_FRAC_BITS;

    logic [DUTY_CODE_W-1:0] code_q;
    logic [LINE_W-1:0]      off_q;
    logic [PW-1:0]          prod;

    assign prod          = PW'(pos_i) * PW'(duty_num(code_q));
    assign drive_phase_o = (pos_i >= off_q);

    // Update off-interval and code only at line boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= DUTY_RESET_CODE;
            off_q  <= '0;
        end else if (line_rise_i) begin
            off_q  <= prod[PW-1:DUTY_FRAC_BITS];
            code_q <= duty_code_i;
        end
    end

endmodule

// File: rtl/defl_bplus_pwm.sv
// B+ switch timing: starts the pulse at mid-flyback, ends it on a current trip,
// at maximum on-time or on loss of permission, then enforces a minimum off
// interval. Assumes pos_i and width_i come from the line timer.
module defl_bplus_pwm #(
    parameter int LINE_W        = 12,
    parameter int MAXON_EIGHTHS = 6,
    parameter int MIN_OFF_CYC   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_rise_i,
    input  logic [LINE_W-1:0] pos_i,
    input  logic [LINE_W-1:0] width_i,
    input  logic              timing_ok_i,
    input  logic              flyback_i,
    input  logic              allow_i,
    input  logic              trip_i,
    output logic              switch_o
);
    localparam int MW = LINE_W + 4;
    localparam int RW = $clog2(MIN_OFF_CYC + 1);

    logic [MW-1:0]     prod;
    logic [LINE_W:0]   maxon_q, oncnt_q;
    logic [RW-1:0]     rest_q;
    logic              start;

    assign prod  = MW'(pos_i) * MW'(MAXON_EIGHTHS);
    assign start = ~switch_o && (rest_q == '0) && allow_i && timing_ok_i &&
                   flyback_i && ~line_rise_i && (pos_i == (width_i >> 1));

    // Maximum on-time taken from the line just measured.
    always_ff @(posedge clk) begin
        if (!rst_n)           maxon_q <= '0;
        else if (line_rise_i) maxon_q <= prod[MW-1:3];
    end

    // Pulse state, on-time counter and forced off interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            switch_o <= 1'b0;
            oncnt_q  <= '0;
            rest_q   <= '0;
        end else if (switch_o) begin
            if (trip_i || (oncnt_q >= maxon_q) || !allow_i) begin
                switch_o <= 1'b0;
                rest_q   <= RW'(MIN_OFF_CYC);
            end else begin
                oncnt_q  <= oncnt_q + 1'b1;
            end
        end else if (start) begin
            switch_o <= 1'b1;
            oncnt_q  <= (LINE_W+1)'(1);
        end else if (rest_q != '0) begin
            rest_q   <= rest_q - 1'b1;
        end
    end

endmodule

// File: rtl/defl_safety_gate.sv
// Top: X-ray fault latch and output gating for horizontal drive, vertical ramp
// and B+ switch. Assumes all inputs are synchronous to clk. The comparators
// are external.
module defl_safety_gate #(
    parameter int LINE_W        = 12,
    parameter int MAXON_EIGHTHS = 6,
    parameter int MIN_OFF_CYC   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xray_i,
    input  logic       vcc_low_i,
    input  logic       vdd_low_i,
    input  logic       xray_clr_i,
    input  logic       flyback_i,
    input  logic       isense_trip_i,
    input  logic       hdrv_en_i,
    input  logic       vramp_en_i,
    input  logic       bplus_en_i,
    input  logic [4:0] duty_code_i,
    output logic       hdrv_o,
    output logic       vramp_o,
    output logic       bplus_o,
    output logic       fault_o
);
    logic              supply_low, bp_allow;
    logic              line_rise, period_ok, width_ok, drive_phase, sw_on;
    logic [LINE_W-1:0] pos, width;

    assign supply_low = vcc_low_i | vdd_low_i;
    assign bp_allow   = ~supply_low & ~fault_o & bplus_en_i;

    // Fault latch: set by X-ray, cleared by supply collapse or command.
    always_ff @(posedge clk) begin
        if (!rst_n)                         fault_o <= 1'b0;
        else if (xray_i)                    fault_o <= 1'b1;
        else if (supply_low || xray_clr_i)  fault_o <= 1'b0;
    end

    defl_line_timer #(.LINE_W(LINE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .flyback_i(flyback_i),
        .line_rise_o(line_rise), .pos_o(pos), .width_o(width),
        .period_ok_o(period_ok), .width_ok_o(width_ok)
    );

    defl_hdrv_duty #(.LINE_W(LINE_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .line_rise_i(line_rise), .pos_i(pos),
        .duty_code_i(duty_code_i), .drive_phase_o(drive_phase)
    );

    defl_bplus_pwm #(
        .LINE_W(LINE_W), .MAXON_EIGHTHS(MAXON_EIGHTHS), .MIN_OFF_CYC(MIN_OFF_CYC)
    ) u_bplus (
        .clk(clk), .rst_n(rst_n), .line_rise_i(line_rise), .pos_i(pos),
        .width_i(width), .timing_ok_i(period_ok & width_ok),
        .flyback_i(flyback_i), .allow_i(bp_allow), .trip_i(isense_trip_i),
        .switch_o(sw_on)
    );

    assign hdrv_o  = period_ok & drive_phase & hdrv_en_i & ~supply_low &
                     ~fault_o & ~flyback_i;
    assign bplus_o = sw_on & bp_allow;
    assign vramp_o = vramp_en_i & ~supply_low;

endmodule

// File: rtl/defl_safety_gate_chk.sv
// Checker: port-level properties of the safety gate, bound to the top.
module defl_safety_gate_chk #(
    parameter int MIN_OFF_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic xray_i,
    input logic vcc_low_i,
    input logic vdd_low_i,
    input logic xray_clr_i,
    input logic flyback_i,
    input logic isense_trip_i,
    input logic vramp_en_i,
    input logic bplus_en_i,
    input logic vramp_o,
    input logic bplus_o,
    input logic fault_o
);
    localparam int CW = $clog2(MIN_OFF_CYC + 1) + 1;
    logic [CW-1:0] low_run;

    // Count low cycles of the B+ output, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                     low_run <= CW'(MIN_OFF_CYC);
        else if (bplus_o)               low_run <= '0;
        else if (low_run < CW'(MIN_OFF_CYC)) low_run <= low_run + 1'b1;
    end

    a_r1_xray_sets: assert property (@(posedge clk) disable iff (!rst_n)
        xray_i |=> fault_o);
    a_r2_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !xray_clr_i && !vcc_low_i && !vdd_low_i) |=> fault_o);
    a_r11_bplus_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low_i || vdd_low_i || fault_o || !bplus_en_i) |-> !bplus_o);
    a_r8_trip_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (bplus_o && isense_trip_i) |=> !bplus_o);
    a_r7_start_in_flyback: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bplus_o) |-> $past(flyback_i));
    a_r10_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bplus_o) |-> (low_run >= CW'(MIN_OFF_CYC)));
    a_r6_vramp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low_i || vdd_low_i || !vramp_en_i) |-> !vramp_o);

endmodule

bind defl_safety_gate defl_safety_gate_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .xray_i(xray_i), .vcc_low_i(vcc_low_i),
    .vdd_low_i(vdd_low_i), .xray_clr_i(xray_clr_i), .flyback_i(flyback_i),
    .isense_trip_i(isense_trip_i), .vramp_en_i(vramp_en_i),
    .bplus_en_i(bplus_en_i), .vramp_o(vramp_o), .bplus_o(bplus_o),
    .fault_o(fault_o)
);

// File: tb/defl_safety_gate_bench.sv
`timescale 1ns/1ps
module defl_safety_gate_bench;
    localparam int MIN_OFF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xray = 0, vcc_low = 0, vdd_low = 0, clr = 0, fb = 0, trip = 0;
    logic hen = 1, ven = 0, ben = 1;
    logic [4:0] code = 5'd31;
    logic hdrv, vramp, bplus, fault;

    int vectors = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_pos = 0, m_off = 0, m_maxon = 0, m_width = 0, m_code = 31;
    int m_oncnt = 0, m_rest = 0, m_pulses = 0;
    bit m_fbq = 0, m_seen = 0, m_pok = 0, m_wok = 0, m_fault = 0, m_on = 0;
    bit prev_bplus = 0;

    // Event injection inside a line.
    int evt_at = -1, evt_kind = 0, evt_len = 1;

    always #10 clk = ~clk;

    defl_safety_gate #(.MIN_OFF_CYC(MIN_OFF)) u_defl_safety_gate (
        .clk(clk), .rst_n(rst_n), .xray_i(xray), .vcc_low_i(vcc_low),
        .vdd_low_i(vdd_low), .xray_clr_i(clr), .flyback_i(fb),
        .isense_trip_i(trip), .hdrv_en_i(hen), .vramp_en_i(ven),
        .bplus_en_i(ben), .duty_code_i(code), .hdrv_o(hdrv),
        .vramp_o(vramp), .bplus_o(bplus), .fault_o(fault)
    );

    function automatic int knum(int c);
        return 39 + c + c / 4;
    endfunction

    // Reference update at a clock edge, from pre-edge inputs and state.
    task automatic model_step();
        bit rise, fall, ok, start;
        int n_pos;
        if (!rst_n) begin
            m_pos = 0; m_off = 0; m_maxon = 0; m_width = 0; m_code = 31;
            m_oncnt = 0; m_rest = 0; m_fbq = 0; m_seen = 0; m_pok = 0;
            m_wok = 0; m_fault = 0; m_on = 0;
            return;
        end
        rise  = fb && !m_fbq;
        fall  = !fb && m_fbq;
        ok    = !vcc_low && !vdd_low && !m_fault && ben;
        start = !m_on && m_rest == 0 && ok && m_pok && m_wok && fb && !rise &&
                m_pos == m_width / 2;
        if (m_on) begin
            if (trip || m_oncnt >= m_maxon || !ok) begin
                m_on = 0; m_rest = MIN_OFF;
            end else m_oncnt++;
        end else if (start) begin
            m_on = 1; m_oncnt = 1; m_pulses++;
        end else if (m_rest > 0) m_rest--;
        n_pos = rise ? 1 : (m_pos < 4095 ? m_pos + 1 : m_pos);
        if (rise) begin
            m_off   = (m_pos * knum(m_code)) / 128;
            m_maxon = (m_pos * 6) / 8;
            m_code  = int'(code);
            if (m_seen) m_pok = 1;
            m_seen  = 1;
        end
        if (fall && m_seen) begin m_width = m_pos; m_wok = 1; end
        if (xray) m_fault = 1;
        else if (vcc_low || vdd_low || clr) m_fault = 0;
        m_pos = n_pos;
        m_fbq = fb;
    endtask

    task automatic cmp(bit act, bit exp, string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the reference, away from the edge.
    task automatic compare_all();
        bit low;
        low = vcc_low || vdd_low;
        cmp(hdrv,  m_pok && m_pos >= m_off && hen && !low && !m_fault && !fb,
            "R3,R4,R5 hdrv_o");
        cmp(bplus, m_on && !low && !m_fault && ben, "R7,R8,R9,R10,R11 bplus_o");
        cmp(vramp, ven && !low, "R6 vramp_o");
        cmp(fault, m_fault, "R1,R2 fault_o");
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        prev_bplus = bplus;
    endtask

    // One line: flyback for fw cycles, optional trip window and injected event.
    task automatic line(int lp, int fw, int trip_at);
        for (int c = 0; c < lp; c++) begin
            fb   = (c < fw);
            trip = (trip_at >= 0 && c >= trip_at && c < trip_at + 2);
            if (c == evt_at) begin
                case (evt_kind)
                    1: xray = 1;
                    2: clr = 1;
                    3: vdd_low = 1;
                    4: vcc_low = 1;
                    default: ;
                endcase
            end
            if (c == evt_at + evt_len) begin
                xray = 0; clr = 0; vdd_low = 0; vcc_low = 0;
            end
            tick();
        end
        evt_at = -1;
    endtask

    initial begin
        int p0;
        for (int i = 0; i < 4; i++) tick();
        // R12: reset state of the outputs.
        cmp(hdrv, 0, "R12 hdrv after reset");
        cmp(bplus, 0, "R12 bplus after reset");
        cmp(fault, 0, "R12 fault after reset");
        rst_n = 1;
        ven = 1;
        // R5, R4 at reset code, R9 maximum on-time.
        for (int i = 0; i < 4; i++) line(100, 10, -1);
        // R4: code changes on consecutive lines, applied one line late.
        code = 5'd0;  line(100, 10, -1);
        code = 5'd16; line(100, 10, -1);
        code = 5'd7;  line(100, 10, -1);
        line(100, 10, -1);
        // R8: current trip ends the pulse.
        line(100, 10, 30);
        line(120, 12, 45);
        // R7: odd flyback width.
        line(64, 7, -1);
        line(64, 7, -1);
        // R10: short lines so the off interval swallows the next start.
        p0 = m_pulses;
        for (int i = 0; i < 6; i++) line(30, 6, -1);
        cmp(m_pulses - p0 < 6, 1, "R10 starts skipped on short lines");
        // R1, R2: X-ray sets the latch, which survives X-ray going low.
        evt_at = 40; evt_kind = 1; evt_len = 1; line(100, 10, -1);
        line(100, 10, -1);
        cmp(fault, 1, "R2 fault held after xray low");
        cmp(hdrv, 0, "R3 hdrv low while fault");
        evt_at = 50; evt_kind = 2; evt_len = 1; line(100, 10, -1);
        cmp(fault, 0, "R2 fault cleared by command");
        // R2: supply collapse clears it.
        evt_at = 20; evt_kind = 1; evt_len = 1; line(100, 10, -1);
        evt_at = 30; evt_kind = 4; evt_len = 1; line(100, 10, -1);
        cmp(fault, 0, "R2 fault cleared by supply low");
        // R11, R3: supply dip in the middle of a B+ pulse.
        line(100, 10, -1);
        evt_at = 20; evt_kind = 3; evt_len = 3; line(100, 10, -1);
        line(100, 10, -1);
        // R11, R3, R6: enable bits.
        ben = 0; line(100, 10, -1); ben = 1;
        hen = 0; line(100, 10, -1); hen = 1;
        ven = 0; line(100, 10, -1);
        cmp(vramp, 0, "R6 vramp off when disabled");
        ven = 1;
        code = 5'd31; line(80, 9, -1); line(80, 9, -1); line(80, 9, 25);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule